// File: doc/BRIEF.md
# Log Ring Base Register Validator

This block is one 64-bit software-visible register slot that holds the base address and size code of a ring buffer in memory. Such a ring might carry commands, events or page requests in an I/O memory management unit. Software writes a full 64-bit word through a valid/ready write channel. The block clears every reserved bit of the word and then runs three checks. A write is kept only if all three pass:

- the base field is aligned;
- the size code is at least the legal minimum;
- when the slot is built as the page-request flavour, the ring is not currently running.

Any other write is thrown away. The stored word stays as it was, and a one-cycle error pulse marks the drop.

Every write that is kept also resets the ring's head and tail pointer registers, which live inside this block. Those pointers can also be loaded through a separate plain pointer-write port. The committed word is decoded continuously into three outputs: a byte base address, an entry count and a ring size in bytes. Whatever consumes the ring, and all memory traffic, sit outside the block.

The write channel never applies back-pressure: `wr_ready` is always high. Every cycle with `wr_valid` high is therefore one complete write. It is accepted or dropped in that same clock edge, and the result is visible from the following cycle.

Top module: `logbar_slot`

## Requirements
- R1: After reset, `rd_data` is 0x0800_0000_0000_0000, which means base field 0 and size code 8 in bits 59:56. At the same time `base_addr` is 0, `entry_count` is 256, `byte_size` is 4096, both pointers are 0 and `wr_err` is 0.
- R2: Only bits 51:12 (base field) and 59:56 (size code) are kept. Bits 63:60, 55:52 and 11:0 always read as zero in `rd_data`, whatever value was written.
- R3: A write is dropped, leaving `rd_data` unchanged, when the low 12 bits of the base field are not all zero. These are register bits 23:12.
- R4: A write is dropped, leaving `rd_data` unchanged, when its size code is below 8. A size code of exactly 8 is accepted.
- R5: With `GATE_ON_RUN`=1 (the default), any write made while `log_running` is high is dropped. The same word written while `log_running` is low is accepted.
- R6: An accepted write sets both `head_ptr` and `tail_ptr` to 0 from the next cycle. A dropped write leaves both pointers unchanged.
- R7: `entry_count` equals 2 to the power of the committed size code. `byte_size` equals `entry_count` times 16. `base_addr` equals `rd_data[51:0]`.
- R8: `wr_err` is high for exactly the one cycle after each dropped write. It stays low after an accepted write and after cycles with no write.
- R9: A pointer write (`ptr_wr_valid`; `ptr_wr_sel` 0 selects head, 1 selects tail) loads `ptr_wr_data` into the selected pointer on the next cycle. If an accepted base write happens in the same cycle, the clear wins.
- R10: `wr_ready` is always high, so no write is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_ready | output | 1 | Always high; the slot never stalls |
| wr_data | input | 64 | Raw word written by software |
| log_running | input | 1 | Ring is active; blocks writes when gating is built in |
| ptr_wr_valid | input | 1 | Pointer load strobe |
| ptr_wr_sel | input | 1 | 0 selects head, 1 selects tail |
| ptr_wr_data | input | PTR_W | Pointer load value |
| rd_data | output | 64 | Committed word with reserved bits zero |
| base_addr | output | 52 | Byte base address of the ring |
| entry_count | output | 16 | Number of entries in the ring |
| byte_size | output | 20 | Ring size in bytes |
| head_ptr | output | PTR_W | Head pointer register |
| tail_ptr | output | PTR_W | Tail pointer register |
| wr_err | output | 1 | One-cycle pulse after a dropped write |

## Verification
A walked table of writes mixes the cases that matter. It includes:

- words full of reserved ones, which separate masking from rejection;
- base fields misaligned at the lowest and highest bit of the 12-bit alignment window;
- size codes 7 and 8, either side of the minimum;
- the same word written with the ring running and then stopped, which isolates the gating from the other checks.

Before each entry, the pointers are loaded with non-zero values, so that a clear (accept) can be told apart from a hold (drop). Directed tests then cover the reset values, back-to-back drops (the error pulse must stay high across both and then fall), and a pointer load landing in the same cycle as a commit.

// File: rtl/logbar_pkg.sv
package logbar_pkg;
  localparam int WORD_W    = 64;
  localparam int BASE_LSB  = 12;
  localparam int BASE_MSB  = 51;
  localparam int LEN_LSB   = 56;
  localparam int LEN_W     = 4;
  localparam int ALIGN_W   = 12;
  localparam int ADDR_W    = BASE_MSB + 1;
  localparam int CNT_W     = 1 << LEN_W;

  function automatic logic [WORD_W-1:0] keep_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = BASE_LSB; i <= BASE_MSB; i++) m[i] = 1'b1;
    for (int i = LEN_LSB; i < LEN_LSB + LEN_W; i++) m[i] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic              take;
    logic              drop;
    logic [WORD_W-1:0] word;
  } verdict_t;
endpackage

// File: rtl/logbar_filter.sv
module logbar_filter
  import logbar_pkg::*;
#(
  parameter int MIN_LEN     = 8,
  parameter bit GATE_ON_RUN = 1'b1
) (
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              running_i,
  output verdict_t          verdict_o
);
  localparam logic [WORD_W-1:0] MASK = keep_mask();

  logic [WORD_W-1:0] clean;
  logic              aligned;
  logic              len_ok;
  logic              blocked;

  always_comb begin
    clean   = data_i & MASK;
    aligned = (clean[BASE_LSB +: ALIGN_W] == '0);
    len_ok  = (clean[LEN_LSB +: LEN_W] >= LEN_W'(MIN_LEN));
    blocked = GATE_ON_RUN && running_i;
    verdict_o.word = clean;
    verdict_o.take = valid_i && aligned && len_ok && !blocked;
    verdict_o.drop = valid_i && !(aligned && len_ok && !blocked);
  end
endmodule

// File: rtl/logbar_store.sv
module logbar_store
  import logbar_pkg::*;
#(
  parameter int RESET_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  verdict_t          verdict_i,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);
  localparam logic [WORD_W-1:0] RST_WORD =
    WORD_W'(RESET_LEN) << LEN_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= RST_WORD;
      err_o  <= 1'b0;
    end else begin
      if (verdict_i.take) word_o <= verdict_i.word;
      err_o <= verdict_i.drop;
    end
  end
endmodule

// File: rtl/logbar_ptrs.sv
module logbar_ptrs #(
  parameter int PTR_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             sel_i,
  input  logic [PTR_W-1:0] data_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o
);
  localparam int NPTR = 2;
  logic [PTR_W-1:0] ptr_q [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[g] <= '0;
      else if (clear_i) ptr_q[g] <= '0;
      else if (load_i && (sel_i == 1'(g))) ptr_q[g] <= data_i;
    end
  end

  assign head_o = ptr_q[0];
  assign tail_o = ptr_q[1];
endmodule

// File: rtl/logbar_decode.sv
module logbar_decode
  import logbar_pkg::*;
#(
  parameter int ENTRY_LOG2 = 4
) (
  input  logic [WORD_W-1:0]           word_i,
  output logic [ADDR_W-1:0]           base_o,
  output logic [CNT_W-1:0]            count_o,
  output logic [CNT_W+ENTRY_LOG2-1:0] bytes_o
);
  logic [LEN_W-1:0] code;

  always_comb begin
    code    = word_i[LEN_LSB +: LEN_W];
    base_o  = word_i[ADDR_W-1:0];
    count_o = CNT_W'(1) << code;
    bytes_o = (CNT_W+ENTRY_LOG2)'(count_o) << ENTRY_LOG2;
  end
endmodule

// File: rtl/logbar_slot.sv
module logbar_slot
  import logbar_pkg::*;
#(
  parameter int PTR_W       = 19,
  parameter int ENTRY_LOG2  = 4,
  parameter int MIN_LEN     = 8,
  parameter int RESET_LEN   = 8,
  parameter bit GATE_ON_RUN = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          log_running,
  input  logic                          ptr_wr_valid,
  input  logic                          ptr_wr_sel,
  input  logic [PTR_W-1:0]              ptr_wr_data,
  output logic [WORD_W-1:0]             rd_data,
  output logic [ADDR_W-1:0]             base_addr,
  output logic [CNT_W-1:0]              entry_count,
  output logic [CNT_W+ENTRY_LOG2-1:0]   byte_size,
  output logic [PTR_W-1:0]              head_ptr,
  output logic [PTR_W-1:0]              tail_ptr,
  output logic                          wr_err
);
  verdict_t verdict;

  assign wr_ready = 1'b1;

  logbar_filter #(.MIN_LEN(MIN_LEN), .GATE_ON_RUN(GATE_ON_RUN)) u_filter (
    .valid_i(wr_valid), .data_i(wr_data), .running_i(log_running),
    .verdict_o(verdict)
  );

  logbar_store #(.RESET_LEN(RESET_LEN)) u_store (
    .clk(clk), .rst_n(rst_n), .verdict_i(verdict),
    .word_o(rd_data), .err_o(wr_err)
  );

  logbar_ptrs #(.PTR_W(PTR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clear_i(verdict.take),
    .load_i(ptr_wr_valid), .sel_i(ptr_wr_sel), .data_i(ptr_wr_data),
    .head_o(head_ptr), .tail_o(tail_ptr)
  );

  logbar_decode #(.ENTRY_LOG2(ENTRY_LOG2)) u_decode (
    .word_i(rd_data), .base_o(base_addr),
    .count_o(entry_count), .bytes_o(byte_size)
  );
endmodule

// File: rtl/logbar_slot_chk.sv
module logbar_slot_chk #(
  parameter int PTR_W       = 19,
  parameter int ENTRY_LOG2  = 4,
  parameter bit GATE_ON_RUN = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_valid,
  input logic                     log_running,
  input logic                     wr_err,
  input logic [63:0]              rd_data,
  input logic [15:0]              entry_count,
  input logic [15+ENTRY_LOG2:0]   byte_size,
  input logic [PTR_W-1:0]         head_ptr,
  input logic [PTR_W-1:0]         tail_ptr
);
  // R2: reserved bits never become visible
  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[63:60] == 4'h0) && (rd_data[55:52] == 4'h0) && (rd_data[11:0] == 12'h0));

  // R3: committed base is always aligned within its field
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[23:12] == 12'h0);

  // R4: committed size code never below the minimum
  p_len_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[59:56] >= 4'd8);

  // R5: writes while running leave the word as it was
  p_run_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (GATE_ON_RUN && wr_valid && log_running) |=> $stable(rd_data));

  // R6: any change of the word comes with cleared pointers
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> (head_ptr == '0 && tail_ptr == '0));

  // R7: size outputs agree with each other
  p_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_count) && byte_size == ((16+ENTRY_LOG2)'(entry_count) << ENTRY_LOG2));

  // R8: an error pulse follows a write, and no write means no change
  p_err_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(rd_data) && !wr_err));
endmodule

bind logbar_slot logbar_slot_chk #(
  .PTR_W(PTR_W), .ENTRY_LOG2(ENTRY_LOG2), .GATE_ON_RUN(GATE_ON_RUN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .log_running(log_running),
  .wr_err(wr_err), .rd_data(rd_data), .entry_count(entry_count),
  .byte_size(byte_size), .head_ptr(head_ptr), .tail_ptr(tail_ptr)
);

// File: tb/tb_logbar_slot.sv
`timescale 1ns/1ps
module tb_logbar_slot;
  localparam int PTR_W = 19;
  localparam logic [63:0] MASK = 64'h0F0F_FFFF_FFFF_F000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic log_running = 1'b0;
  logic ptr_wr_valid = 1'b0;
  logic ptr_wr_sel = 1'b0;
  logic [PTR_W-1:0] ptr_wr_data = '0;
  logic wr_ready, wr_err;
  logic [63:0] rd_data;
  logic [51:0] base_addr;
  logic [15:0] entry_count;
  logic [19:0] byte_size;
  logic [PTR_W-1:0] head_ptr, tail_ptr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  logbar_slot dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .log_running(log_running), .ptr_wr_valid(ptr_wr_valid),
    .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data), .rd_data(rd_data),
    .base_addr(base_addr), .entry_count(entry_count), .byte_size(byte_size),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .wr_err(wr_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs already set at a negedge; return at the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_ptr(input logic sel, input logic [PTR_W-1:0] v);
    ptr_wr_valid = 1'b1; ptr_wr_sel = sel; ptr_wr_data = v;
    tick();
    ptr_wr_valid = 1'b0;
  endtask

  task automatic write_word(input logic [63:0] d, input logic run);
    wr_valid = 1'b1; wr_data = d; log_running = run;
    tick();
    wr_valid = 1'b0; log_running = 1'b0;
  endtask

  task automatic check_sizes(input string req, input logic [63:0] word);
    logic [15:0] cnt;
    cnt = 16'(1) << word[59:56];
    chk(req, 64'(entry_count), 64'(cnt));
    chk(req, 64'(byte_size), 64'(cnt) * 16);
    chk(req, 64'(base_addr), {12'h0, word[51:0]});
  endtask

  // {run, accept, data}
  localparam int NV = 9;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b1, 64'hF9F0_0000_0100_0FFF},  // R2 reserved ones stripped
    {1'b0, 1'b0, 64'h0A00_0000_0000_3000},  // R3 low alignment bits
    {1'b0, 1'b1, 64'h0A00_0001_0000_0000},  // accept, size 10
    {1'b0, 1'b0, 64'h0700_0000_0200_0000},  // R4 size 7 dropped
    {1'b0, 1'b1, 64'h0800_0000_0300_0000},  // R4 size 8 kept
    {1'b1, 1'b0, 64'h0F00_0000_0400_0000},  // R5 running blocks
    {1'b0, 1'b1, 64'h0F00_0000_0400_0000},  // R5 same word, stopped
    {1'b0, 1'b0, 64'h0C00_0000_0080_0000},  // R3 top alignment bit
    {1'b0, 1'b1, 64'h0C00_0010_0000_0ABC}   // accept, size 12
  };

  initial begin
    logic [63:0] model;
    model = 64'h0800_0000_0000_0000;
    #23;
    @(negedge clk);
    // R1 reset values
    chk("R1 rd_data", rd_data, model);
    chk("R1 wr_err", 64'(wr_err), 64'd0);
    chk("R1 head", 64'(head_ptr), 64'd0);
    chk("R1 tail", 64'(tail_ptr), 64'd0);
    check_sizes("R1 sizes", model);
    rst_n = 1'b1;
    tick();
    chk("R10 wr_ready", 64'(wr_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      logic run, acc;
      logic [63:0] d;
      {run, acc, d} = VEC[i];
      load_ptr(1'b0, PTR_W'(5 + i));
      load_ptr(1'b1, PTR_W'(9 + i));
      chk("R9 ptr load head", 64'(head_ptr), 64'(5 + i));
      write_word(d, run);
      if (acc) model = d & MASK;
      chk("R2 R3 R4 R5 word", rd_data, model);
      chk("R8 err pulse", 64'(wr_err), acc ? 64'd0 : 64'd1);
      chk("R6 head", 64'(head_ptr), acc ? 64'd0 : 64'(5 + i));
      chk("R6 tail", 64'(tail_ptr), acc ? 64'd0 : 64'(9 + i));
      check_sizes("R7 decode", model);
      tick();
      chk("R8 err one cycle", 64'(wr_err), 64'd0);
    end

    // R8 back-to-back drops
    wr_valid = 1'b1; wr_data = 64'h0300_0000_0000_0000;
    tick();
    chk("R8 first drop", 64'(wr_err), 64'd1);
    wr_data = 64'h0900_0000_0000_1000;
    tick();
    wr_valid = 1'b0;
    chk("R8 second drop", 64'(wr_err), 64'd1);
    chk("R3 still held", rd_data, model);
    tick();
    chk("R8 pulse falls", 64'(wr_err), 64'd0);

    // R9 clear wins over pointer load in the same cycle
    load_ptr(1'b1, PTR_W'(33));
    wr_valid = 1'b1; wr_data = 64'h0B00_0000_0500_0000;
    ptr_wr_valid = 1'b1; ptr_wr_sel = 1'b0; ptr_wr_data = PTR_W'(7);
    tick();
    wr_valid = 1'b0; ptr_wr_valid = 1'b0;
    model = 64'h0B00_0000_0500_0000;
    chk("R9 clear priority head", 64'(head_ptr), 64'd0);
    chk("R9 clear priority tail", 64'(tail_ptr), 64'd0);
    chk("R9 word", rd_data, model);
    load_ptr(1'b0, PTR_W'(7));
    chk("R9 load after", 64'(head_ptr), 64'd7);
    chk("R9 tail untouched", 64'(tail_ptr), 64'd0);

    // R1 reset again restores defaults
    rst_n = 1'b0;
    tick();
    chk("R1 reset word", rd_data, 64'h0800_0000_0000_0000);
    chk("R1 reset head", 64'(head_ptr), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule